// File: doc/BRIEF.md
# Two-Stage Accumulate and Moving-Sum Decimator

This block sits behind a converter front end. It takes a stream of conversion results, each with a valid strobe and a two-bit channel tag, and filters them in two steps. The first step is a decimator. It adds a programmable number of accepted samples into a current-sum register. When that count is reached, the second step adds the finished sum to the most recent older sums, which are held in a shift chain of intermediate registers. The result goes into a final-result register, and the block raises a service request.

The input stage can take one channel, any channel, or a cascade input. The cascade input carries another filter's output, already reduced to the sample width. The input stage can also stop the filter. The chain depth is a parameter: 4 for the deep variant and 2 for the shallow one. The accumulator widths are derived so that neither sum can overflow. The current, intermediate and final registers are all visible on output ports, together with the sample down-counter.

A write to the control inputs takes effect on the next clock edge and restarts filtering from a clean state.

Top module: `acc_avg_decim`

## Requirements
- R1: After reset, `cur_sum`, `ac_cnt`, `ir_flat`, `final_res`, `srv_req` and `irq_flag` are all zero, and the filter is halted until it is configured.
- R2: Select codes 0 to 3 accept a converter sample only when `smp_valid` is high and `smp_chan` equals the code. Samples with any other tag leave `cur_sum` and `ac_cnt` unchanged.
- R3: Select code 4 accepts every valid converter sample, whatever its tag. Select code 5 accepts only `casc_valid`/`casc_data` and ignores converter samples.
- R4: Select codes 6 and 7 halt the filter. No sample is accepted, `cur_sum` holds its value and `final_res` is not updated.
- R5: Each accepted sample is sign-extended (when `SIGNED_IN` is 1) and added to `cur_sum`. `ac_cnt` is loaded with the addition-length code A and decrements on each accepted sample. One intermediate result is the sum of A+1 samples, so code 3 gives four samples.
- R6: One cycle after the last sample of an accumulation cycle is accepted, `final_res` becomes the finished current sum plus intermediate stages 1 to M. M is the moving-length code, capped at DEPTH-1, so the sum covers M+1 values. Stages that are not selected contribute zero.
- R7: In that same cycle the chain shifts: stage k takes the value of stage k-1, stage 1 takes the finished sum, and the oldest stage is dropped. `cur_sum` restarts from zero, and a sample accepted in that cycle is added to the restarted sum. Stage k occupies `ir_flat[k*ACC_W-1 -: ACC_W]`.
- R8: `srv_req` is high for exactly the cycle in which `final_res` shows a new value, and `irq_flag` is set on that same edge.
- R9: `irq_clr` clears `irq_flag`. When a final update and a clear fall on the same edge, the flag stays set.
- R10: `cfg_we` loads the select, addition-length and moving-length codes. On the same edge it clears `cur_sum` and all chain stages and reloads `ac_cnt` with the new length, so no earlier data reaches a later final result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load control codes and restart |
| cfg_insel | input | 3 | Input select code (0-3 channel, 4 all, 5 cascade, 6/7 halt) |
| cfg_addl | input | ADD_W | Addition-length code A (A+1 samples) |
| cfg_mavl | input | 2 | Moving-length code M (M+1 sums) |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | IN_W | Converter sample value |
| smp_chan | input | 2 | Converter channel tag |
| casc_valid | input | 1 | Cascade input strobe |
| casc_data | input | IN_W | Cascade input value |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| cur_sum | output | ACC_W | Current sum register |
| ac_cnt | output | ADD_W | Remaining-sample down-counter |
| ir_flat | output | (DEPTH-1)*ACC_W | Intermediate stages 1 to DEPTH-1, stage 1 in the low bits |
| final_res | output | FR_W | Final result register |
| srv_req | output | 1 | One-cycle service request on each final update |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench sweeps every select code against every addition length from 1 to 4 samples and every moving length. Each step mixes on-target and off-target samples, so a wrong tag compare or a leaky halt shows up at once as a drifting current sum. A separate run feeds samples back to back, with one arriving in the cycle the final result is formed. A design that cleared the sum after adding that sample would lose it, and one that failed to shift the chain would repeat an old intermediate. Reconfiguring after each sweep point with a full chain exposes any stage that survives a restart. The same-edge clear test catches a flag where the clear wins over the set.

// File: rtl/accavg_pkg.sv
`timescale 1ns/1ps
package accavg_pkg;
   localparam int NUM_CH = 4;
   localparam int CH_W   = 2;
   localparam int MAV_W  = 2;

   typedef enum logic [2:0] {
      SEL_CH0  = 3'd0,
      SEL_CH1  = 3'd1,
      SEL_CH2  = 3'd2,
      SEL_CH3  = 3'd3,
      SEL_ALL  = 3'd4,
      SEL_CASC = 3'd5,
      SEL_OFFA = 3'd6,
      SEL_OFFB = 3'd7
   } sel_e;
endpackage

// File: rtl/accavg_insel.sv
`timescale 1ns/1ps
module accavg_insel
   import accavg_pkg::*;
#(
   parameter int IN_W = 10
) (
   input  logic [2:0]      sel,
   input  logic            smp_valid,
   input  logic [IN_W-1:0] smp_data,
   input  logic [CH_W-1:0] smp_chan,
   input  logic            casc_valid,
   input  logic [IN_W-1:0] casc_data,
   output logic            take,
   output logic [IN_W-1:0] value
);
   sel_e mode;
   assign mode = sel_e'(sel);

   always_comb begin
      take  = 1'b0;
      value = smp_data;
      case (mode)
         SEL_CH0, SEL_CH1, SEL_CH2, SEL_CH3:
            take = smp_valid && (smp_chan == sel[CH_W-1:0]);
         SEL_ALL:
            take = smp_valid;
         SEL_CASC: begin
            take  = casc_valid;
            value = casc_data;
         end
         default:
            take = 1'b0;
      endcase
   end
endmodule

// File: rtl/accavg_accum.sv
`timescale 1ns/1ps
module accavg_accum #(
   parameter int IN_W      = 10,
   parameter int ADD_W     = 4,
   parameter int SIGNED_IN = 1,
   localparam int ACC_W    = IN_W + ADD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [ADD_W-1:0] addl_new,
   input  logic [ADD_W-1:0] addl_q,
   input  logic             take,
   input  logic [IN_W-1:0]  value,
   output logic [ACC_W-1:0] acc_q,
   output logic [ADD_W-1:0] cnt_q,
   output logic             fire_q
);
   logic [ACC_W-1:0] samp_ext;
   logic [ACC_W-1:0] base;

   if (SIGNED_IN != 0) begin : g_sext
      assign samp_ext = {{ADD_W{value[IN_W-1]}}, value};
   end else begin : g_zext
      assign samp_ext = {{ADD_W{1'b0}}, value};
   end

   // After a completed cycle the sum restarts from zero, but the
   // sample arriving in that same cycle is still counted.
   assign base = fire_q ? '0 : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else if (restart) begin
         acc_q  <= '0;
         cnt_q  <= addl_new;
         fire_q <= 1'b0;
      end else begin
         acc_q  <= base + (take ? samp_ext : '0);
         fire_q <= take && (cnt_q == '0);
         if (take)
            cnt_q <= (cnt_q == '0) ? addl_q : cnt_q - 1'b1;
      end
   end

   a_r5_fire_after_last : assert property (@(posedge clk) disable iff (!rst_n)
      (fire_q && !$past(restart)) |-> ($past(take) && ($past(cnt_q) == '0)));
endmodule

// File: rtl/accavg_chain.sv
`timescale 1ns/1ps
module accavg_chain
   import accavg_pkg::*;
#(
   parameter int ACC_W     = 14,
   parameter int DEPTH     = 4,
   parameter int SIGNED_IN = 1,
   localparam int FR_W     = ACC_W + $clog2(DEPTH),
   localparam int GROW     = FR_W - ACC_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       restart,
   input  logic                       fire,
   input  logic [ACC_W-1:0]           acc_in,
   input  logic [MAV_W-1:0]           mavl,
   output logic [(DEPTH-1)*ACC_W-1:0] ir_flat,
   output logic [FR_W-1:0]            final_q,
   output logic                       srv_q
);
   logic [ACC_W-1:0] ir_q [1:DEPTH-1];
   logic [FR_W-1:0]  sum;

   function automatic logic [FR_W-1:0] widen(input logic [ACC_W-1:0] v);
      return (SIGNED_IN != 0) ? {{GROW{v[ACC_W-1]}}, v} : {{GROW{1'b0}}, v};
   endfunction

   always_comb begin
      sum = widen(acc_in);
      for (int k = 1; k < DEPTH; k++)
         if (k <= int'(mavl))
            sum = sum + widen(ir_q[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 1; k < DEPTH; k++) ir_q[k] <= '0;
         final_q <= '0;
         srv_q   <= 1'b0;
      end else if (restart) begin
         for (int k = 1; k < DEPTH; k++) ir_q[k] <= '0;
         srv_q <= 1'b0;
      end else begin
         srv_q <= fire;
         if (fire) begin
            final_q <= sum;
            for (int k = DEPTH - 1; k > 1; k--) ir_q[k] <= ir_q[k-1];
            ir_q[1] <= acc_in;
         end
      end
   end

   for (genvar k = 1; k < DEPTH; k++) begin : g_flat
      assign ir_flat[k*ACC_W-1 -: ACC_W] = ir_q[k];
   end

   if (DEPTH > 2) begin : g_deep_chk
      a_r7_stage2_shift : assert property (@(posedge clk) disable iff (!rst_n)
         srv_q |-> (ir_q[2] == $past(ir_q[1])));
   end
endmodule

// File: rtl/acc_avg_decim.sv
`timescale 1ns/1ps
module acc_avg_decim
   import accavg_pkg::*;
#(
   parameter int  IN_W      = 10,
   parameter int  ADD_W     = 4,
   parameter int  DEPTH     = 4,
   parameter int  SIGNED_IN = 1,
   localparam int ACC_W     = IN_W + ADD_W,
   localparam int FR_W      = ACC_W + $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [2:0]                 cfg_insel,
   input  logic [ADD_W-1:0]           cfg_addl,
   input  logic [1:0]                 cfg_mavl,
   input  logic                       smp_valid,
   input  logic [IN_W-1:0]            smp_data,
   input  logic [1:0]                 smp_chan,
   input  logic                       casc_valid,
   input  logic [IN_W-1:0]            casc_data,
   input  logic                       irq_clr,
   output logic [ACC_W-1:0]           cur_sum,
   output logic [ADD_W-1:0]           ac_cnt,
   output logic [(DEPTH-1)*ACC_W-1:0] ir_flat,
   output logic [FR_W-1:0]            final_res,
   output logic                       srv_req,
   output logic                       irq_flag
);
   if (DEPTH != 2 && DEPTH != 4) begin : g_bad_depth
      $error("DEPTH must be 2 or 4");
   end
   if (IN_W < 2 || ADD_W < 1) begin : g_bad_width
      $error("IN_W must be at least 2 and ADD_W at least 1");
   end

   logic [2:0]       insel_q;
   logic [ADD_W-1:0] addl_q;
   logic [MAV_W-1:0] mavl_q;
   logic             take;
   logic [IN_W-1:0]  value;
   logic             fire;
   logic             upd;
   logic             halted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insel_q <= SEL_OFFB;
         addl_q  <= '0;
         mavl_q  <= '0;
      end else if (cfg_we) begin
         insel_q <= cfg_insel;
         addl_q  <= cfg_addl;
         mavl_q  <= cfg_mavl;
      end
   end

   assign halted = (insel_q == SEL_OFFA) || (insel_q == SEL_OFFB);
   assign upd    = fire && !cfg_we;

   accavg_insel #(.IN_W(IN_W)) i_insel (
      .sel(insel_q), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_chan(smp_chan), .casc_valid(casc_valid), .casc_data(casc_data),
      .take(take), .value(value)
   );

   accavg_accum #(.IN_W(IN_W), .ADD_W(ADD_W), .SIGNED_IN(SIGNED_IN)) i_accum (
      .clk(clk), .rst_n(rst_n), .restart(cfg_we), .addl_new(cfg_addl),
      .addl_q(addl_q), .take(take), .value(value),
      .acc_q(cur_sum), .cnt_q(ac_cnt), .fire_q(fire)
   );

   accavg_chain #(.ACC_W(ACC_W), .DEPTH(DEPTH), .SIGNED_IN(SIGNED_IN)) i_chain (
      .clk(clk), .rst_n(rst_n), .restart(cfg_we), .fire(fire),
      .acc_in(cur_sum), .mavl(mavl_q), .ir_flat(ir_flat),
      .final_q(final_res), .srv_q(srv_req)
   );

   // Set beats clear on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq_flag <= 1'b0;
      else if (upd)      irq_flag <= 1'b1;
      else if (irq_clr)  irq_flag <= 1'b0;
   end

   a_r5_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      ac_cnt <= addl_q);

   a_r4_halt_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !fire && !cfg_we) |=> $stable(cur_sum));

   a_r8_final_only_on_req : assert property (@(posedge clk) disable iff (!rst_n)
      !srv_req |-> $stable(final_res));

   a_r8_flag_with_req : assert property (@(posedge clk) disable iff (!rst_n)
      srv_req |-> irq_flag);

   a_r9_clear_works : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !upd) |=> !irq_flag);

   a_r7_stage1_load : assert property (@(posedge clk) disable iff (!rst_n)
      srv_req |-> (ir_flat[ACC_W-1:0] == $past(cur_sum)));

   a_r10_restart_clears : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (ir_flat == '0 && ac_cnt == $past(cfg_addl)));
endmodule

// File: tb/test_acc_avg_decim.sv
`timescale 1ns/1ps
module test_acc_avg_decim;
   localparam int IN_W = 10, ADD_W = 4, DEPTH = 4;
   localparam int ACC_W = IN_W + ADD_W, FR_W = ACC_W + 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                       rst_n;
   logic                       cfg_we;
   logic [2:0]                 cfg_insel;
   logic [ADD_W-1:0]           cfg_addl;
   logic [1:0]                 cfg_mavl;
   logic                       smp_valid;
   logic [IN_W-1:0]            smp_data;
   logic [1:0]                 smp_chan;
   logic                       casc_valid;
   logic [IN_W-1:0]            casc_data;
   logic                       irq_clr;
   logic [ACC_W-1:0]           cur_sum;
   logic [ADD_W-1:0]           ac_cnt;
   logic [(DEPTH-1)*ACC_W-1:0] ir_flat;
   logic [FR_W-1:0]            final_res;
   logic                       srv_req;
   logic                       irq_flag;

   acc_avg_decim #(.IN_W(IN_W), .ADD_W(ADD_W), .DEPTH(DEPTH), .SIGNED_IN(1)) i_acc_avg_decim (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_insel(cfg_insel),
      .cfg_addl(cfg_addl), .cfg_mavl(cfg_mavl), .smp_valid(smp_valid),
      .smp_data(smp_data), .smp_chan(smp_chan), .casc_valid(casc_valid),
      .casc_data(casc_data), .irq_clr(irq_clr), .cur_sum(cur_sum),
      .ac_cnt(ac_cnt), .ir_flat(ir_flat), .final_res(final_res),
      .srv_req(srv_req), .irq_flag(irq_flag)
   );

   int nchk = 0, nfail = 0;
   int m_sum, m_cnt, m_addl, m_mavl, m_sel;
   int m_ir [1:3];

   function automatic int sx(input int raw);
      return (raw >= 512) ? raw - 1024 : raw;
   endfunction

   function automatic int irv(input int k);
      logic [ACC_W-1:0] s;
      s = ir_flat[k*ACC_W-1 -: ACC_W];
      return int'($signed(s));
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle_in();
      cfg_we = 0; smp_valid = 0; casc_valid = 0; irq_clr = 0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic configure(input int sel, input int addl, input int mavl);
      idle_in();
      cfg_we = 1; cfg_insel = sel[2:0]; cfg_addl = addl[ADD_W-1:0]; cfg_mavl = mavl[1:0];
      step();
      idle_in();
      m_sel = sel; m_addl = addl; m_mavl = mavl; m_sum = 0; m_cnt = 0;
      for (int k = 1; k <= 3; k++) m_ir[k] = 0;
      chk("R10 cur_sum after restart", int'($signed(cur_sum)), 0);
      chk("R10 ac_cnt after restart", ac_cnt, addl);
      for (int k = 1; k <= 3; k++) chk("R10 stage after restart", irv(k), 0);
   endtask

   task automatic feed(input bit v, input int raw, input int ch, input bit cv, input int craw);
      bit acc;
      int val, exp_f, lim;
      string tag;
      smp_valid = v; smp_data = raw[IN_W-1:0]; smp_chan = ch[1:0];
      casc_valid = cv; casc_data = craw[IN_W-1:0];
      step();
      idle_in();
      if (m_sel == 5) begin acc = cv; val = sx(craw); end
      else if (m_sel == 4) begin acc = v; val = sx(raw); end
      else if (m_sel < 4) begin acc = v && (ch == m_sel); val = sx(raw); end
      else begin acc = 0; val = 0; end
      if (acc) begin m_sum += val; m_cnt++; end
      tag = acc ? "R5" : (m_sel >= 6 ? "R4" : (m_sel == 5 ? "R3" : "R2"));
      if (m_cnt == m_addl + 1) begin
         chk("R5 full sum", int'($signed(cur_sum)), m_sum);
         step();
         lim = (m_mavl < DEPTH - 1) ? m_mavl : DEPTH - 1;
         exp_f = m_sum;
         for (int k = 1; k <= lim; k++) exp_f += m_ir[k];
         m_ir[3] = m_ir[2]; m_ir[2] = m_ir[1]; m_ir[1] = m_sum;
         m_sum = 0; m_cnt = 0;
         chk("R6 final_res", int'($signed(final_res)), exp_f);
         for (int k = 1; k <= 3; k++) chk("R7 stage", irv(k), m_ir[k]);
         chk("R7 cur_sum cleared", int'($signed(cur_sum)), 0);
         chk("R8 srv_req", srv_req, 1);
         chk("R8 irq_flag", irq_flag, 1);
         chk("R5 ac_cnt reload", ac_cnt, m_addl);
      end else begin
         chk(tag, int'($signed(cur_sum)), m_sum);
         chk({tag, " ac_cnt"}, ac_cnt, m_addl - m_cnt);
         chk("R8 no srv_req", srv_req, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      int a, b, c, d, e;
      rst_n = 0; idle_in();
      cfg_insel = 0; cfg_addl = 0; cfg_mavl = 0;
      smp_data = 0; smp_chan = 0; casc_data = 0;
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 cur_sum", cur_sum, 0);
      chk("R1 ac_cnt", ac_cnt, 0);
      chk("R1 ir_flat", ir_flat, 0);
      chk("R1 final_res", final_res, 0);
      chk("R1 srv_req", srv_req, 0);
      chk("R1 irq_flag", irq_flag, 0);
      smp_valid = 1; smp_data = 10'd5; smp_chan = 0;
      step(); idle_in();
      chk("R1 halted after reset", cur_sum, 0);

      // Sweep of select, addition length and moving length (R2 R3 R4 R5 R6 R7 R8 R10)
      for (int sel = 0; sel < 8; sel++)
         for (int addl = 0; addl < 4; addl++)
            for (int mavl = 0; mavl < 4; mavl++) begin
               configure(sel, addl, mavl);
               for (int r = 0; r < 6; r++)
                  for (int s = 0; s < 4; s++) begin
                     int raw1, raw2, raw3;
                     raw1 = (sel*131 + addl*57 + mavl*29 + r*71 + s*13) % 1024;
                     raw2 = (sel*37 + addl*211 + mavl*5 + r*97 + s*389) % 1024;
                     raw3 = (sel*17 + addl*83 + mavl*151 + r*263 + s*7) % 1024;
                     feed(1, raw1, (sel + 1) % 4, 0, 0);
                     feed(1, raw2, sel % 4, sel == 5, raw3);
                  end
            end

      // R7: samples back to back, one landing in the final-update cycle
      configure(4, 1, 3);
      a = 100; b = -50; c = 7; d = 200; e = -3;
      smp_valid = 1; smp_chan = 2;
      smp_data = a[IN_W-1:0]; step();
      smp_data = b[IN_W-1:0]; step();
      smp_data = c[IN_W-1:0]; step();
      chk("R7 b2b final", int'($signed(final_res)), a + b);
      chk("R7 b2b cur_sum keeps sample", int'($signed(cur_sum)), c);
      chk("R7 b2b stage1", irv(1), a + b);
      chk("R8 b2b srv_req", srv_req, 1);
      smp_data = d[IN_W-1:0]; step();
      smp_data = e[IN_W-1:0]; step();
      idle_in();
      chk("R6 b2b final", int'($signed(final_res)), a + b + c + d);
      chk("R7 b2b stage1 second", irv(1), c + d);
      chk("R7 b2b stage2", irv(2), a + b);
      chk("R7 b2b cur_sum second", int'($signed(cur_sum)), e);

      // R9: set wins over clear on the same edge, then clear alone
      configure(4, 0, 0);
      smp_valid = 1; smp_chan = 1; smp_data = 10'd9; step();
      idle_in(); irq_clr = 1; step();
      chk("R9 set beats clear", irq_flag, 1);
      chk("R8 srv with clear", srv_req, 1);
      irq_clr = 1; step();
      chk("R9 clear", irq_flag, 0);
      irq_clr = 0; step();
      chk("R9 stays clear", irq_flag, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule